// File: doc/BRIEF.md
# Processor Status Word with Privilege Stack Swap

This block holds a processor's 16-bit status word as separate fields: a privilege bit, a 3-bit interrupt priority mask and five condition flags. The read port always presents these fields packed into one word. A write to the status word unpacks the incoming word back into the fields. A separate flag port lets execution logic update single condition flags without touching the privilege bit or the mask.

The block also owns three 32-bit stack pointer registers. The active stack pointer (`sp_act`) is the one instructions address. Two shadows hold the user-level pointer (`sp_usr`) and the privileged pointer (`sp_sup`). When a status-word write changes the privilege bit, the block saves the active pointer into the shadow of the level being left and loads it from the shadow of the level being entered. This happens on the same clock edge as the write.

A two-state machine tracks the privilege level. Its states are `PRIV_USER` and `PRIV_SUPER`. It has four transitions:
- `ENTER_SUPER`: from `PRIV_USER`, a status write with bit 13 set.
- `LEAVE_SUPER`: from `PRIV_SUPER`, a status write with bit 13 clear.
- `STAY_USER`: in `PRIV_USER`, any other cycle.
- `STAY_SUPER`: in `PRIV_SUPER`, any other cycle.

Top module: `status_word_unit`

## Requirements
- R1: `sw_rdata` presents the fields in this layout: privilege at bit 13, mask at bits 10:8, X at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. Bits 15:14, 7:5 and 12:11 always read 0.
- R2: When `sw_we` is high, all fields load from those bit positions of `sw_wdata`, and `sw_rdata` shows them from the next cycle. The unlisted bits of `sw_wdata` have no effect.
- R3: On `LEAVE_SUPER`, `sp_sup` receives the old `sp_act`, and `sp_act` receives the old `sp_usr`. `sp_usr` keeps its value.
- R4: On `ENTER_SUPER`, `sp_usr` receives the old `sp_act`, and `sp_act` receives the old `sp_sup`. `sp_sup` keeps its value.
- R5: A status write that leaves the privilege bit unchanged moves no stack pointer.
- R6: On the flag port, `flag_we[i]` loads `flag_wdata[i]`. Index 4 is X, 3 is N, 2 is Z, 1 is V and 0 is C. Flags whose enable is low keep their value. When `sw_we` is high in the same cycle, the status write wins for every flag.
- R7: Outside a swap cycle, `sp_act_we`, `sp_usr_we` and `sp_sup_we` load their register from the matching write data. In a swap cycle, the swap wins and all three direct writes are ignored.
- R8: After reset the privilege bit is 1, the mask is 7 and all flags are 0, so `sw_rdata` is 0x2700. All three stack pointers reset to 0.
- R9: `priv_o` equals `sw_rdata` bit 13, and `imask_o` equals `sw_rdata` bits 10:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_we | input | 1 | Status word write strobe |
| sw_wdata | input | 16 | Status word write data |
| sw_rdata | output | 16 | Packed status word |
| flag_we | input | 5 | Per-flag write enables (X,N,Z,V,C at 4..0) |
| flag_wdata | input | 5 | Per-flag write data |
| priv_o | output | 1 | Current privilege bit |
| imask_o | output | 3 | Current interrupt mask |
| sp_act_we | input | 1 | Active stack pointer direct write |
| sp_act_wdata | input | 32 | Active stack pointer write data |
| sp_act_q | output | 32 | Active stack pointer |
| sp_usr_we | input | 1 | User shadow direct write |
| sp_usr_wdata | input | 32 | User shadow write data |
| sp_usr_q | output | 32 | User shadow pointer |
| sp_sup_we | input | 1 | Privileged shadow direct write |
| sp_sup_wdata | input | 32 | Privileged shadow write data |
| sp_sup_q | output | 32 | Privileged shadow pointer |

## Verification
Every result here is held in a register and is due exactly one rising edge after its strobe. This covers the packed word, the flag updates, the direct pointer writes and the swaps. The bench drives each strobe one time unit after an edge and lets the next edge capture it. It samples one time unit after that edge and then drops the strobe, so each check sees the state of the one edge that acted on it. Expected pointer values come from a small bench-side model of the three registers. That model is updated by the same rules the requirements give.

// File: rtl/swu_pkg.sv
package swu_pkg;

    localparam int SW_W      = 16;
    localparam int PRIV_BIT  = 13;
    localparam int MASK_LO   = 8;
    localparam int MASK_W    = 3;
    localparam int FLAG_N    = 5;
    localparam logic [SW_W-1:0] SW_KEEP = 16'h271F;
    localparam logic [MASK_W-1:0] MASK_RESET = '1;

    typedef enum logic {
        PRIV_USER  = 1'b0,
        PRIV_SUPER = 1'b1
    } priv_e;

    typedef enum logic [1:0] {
        STAY_USER,
        STAY_SUPER,
        ENTER_SUPER,
        LEAVE_SUPER
    } priv_move_e;

    function automatic logic [SW_W-1:0] pack_word(
        input logic              priv,
        input logic [MASK_W-1:0] mask,
        input logic [FLAG_N-1:0] flags
    );
        logic [SW_W-1:0] w;
        w = '0;
        w[PRIV_BIT] = priv;
        w[MASK_LO +: MASK_W] = mask;
        w[FLAG_N-1:0] = flags;
        return w;
    endfunction

endpackage

// File: rtl/swu_priv_fsm.sv
module swu_priv_fsm
    import swu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_priv,
    output logic priv_q,
    output logic enter_super,
    output logic leave_super
);

    priv_e      state_q;
    priv_e      state_d;
    priv_move_e move;

    // Transition selection
    always_comb begin
        move = STAY_SUPER;
        unique case (state_q)
            PRIV_USER:  move = (wr_en && wr_priv)  ? ENTER_SUPER : STAY_USER;
            PRIV_SUPER: move = (wr_en && !wr_priv) ? LEAVE_SUPER : STAY_SUPER;
            default:    move = STAY_SUPER;
        endcase
    end

    // Outputs and next state
    always_comb begin
        enter_super = 1'b0;
        leave_super = 1'b0;
        state_d     = state_q;
        unique case (move)
            ENTER_SUPER: begin
                enter_super = 1'b1;
                state_d     = PRIV_SUPER;
            end
            LEAVE_SUPER: begin
                leave_super = 1'b1;
                state_d     = PRIV_USER;
            end
            STAY_USER:  state_d = PRIV_USER;
            STAY_SUPER: state_d = PRIV_SUPER;
            default:    state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PRIV_SUPER;
        else        state_q <= state_d;
    end

    assign priv_q = (state_q == PRIV_SUPER);

    p_one_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(enter_super && leave_super));

    p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_priv && !priv_q) |=> priv_q);

    p_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv && priv_q) |=> !priv_q);

endmodule

// File: rtl/swu_ccr_bank.sv
module swu_ccr_bank
    import swu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [MASK_W-1:0] sw_mask,
    input  logic [FLAG_N-1:0] sw_flags,
    input  logic [FLAG_N-1:0] flag_we,
    input  logic [FLAG_N-1:0] flag_wdata,
    output logic [MASK_W-1:0] mask_q,
    output logic [FLAG_N-1:0] flags_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mask_q <= MASK_RESET;
        else if (sw_we) mask_q <= sw_mask;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (sw_we)      flags_q[i] <= sw_flags[i];
            else if (flag_we[i]) flags_q[i] <= flag_wdata[i];
        end

        p_flag_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_we[i] && !sw_we) |=> (flags_q[i] == $past(flag_wdata[i])));

        p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_we[i] && !sw_we) |=> $stable(flags_q[i]));
    end

endmodule

// File: rtl/swu_stack_bank.sv
module swu_stack_bank #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_super,
    input  logic             leave_super,
    input  logic             act_we,
    input  logic [PTR_W-1:0] act_wdata,
    input  logic             usr_we,
    input  logic [PTR_W-1:0] usr_wdata,
    input  logic             sup_we,
    input  logic [PTR_W-1:0] sup_wdata,
    output logic [PTR_W-1:0] act_q,
    output logic [PTR_W-1:0] usr_q,
    output logic [PTR_W-1:0] sup_q
);

    logic swap;
    assign swap = enter_super || leave_super;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            usr_q <= '0;
            sup_q <= '0;
        end else if (enter_super) begin
            usr_q <= act_q;
            act_q <= sup_q;
        end else if (leave_super) begin
            sup_q <= act_q;
            act_q <= usr_q;
        end else begin
            if (act_we) act_q <= act_wdata;
            if (usr_we) usr_q <= usr_wdata;
            if (sup_we) sup_q <= sup_wdata;
        end
    end

    p_swap_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enter_super |=> (usr_q == $past(act_q) && act_q == $past(sup_q)
                         && sup_q == $past(sup_q)));

    p_swap_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        leave_super |=> (sup_q == $past(act_q) && act_q == $past(usr_q)
                         && usr_q == $past(usr_q)));

    p_no_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap && !act_we) |=> $stable(act_q));

    p_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap && usr_we) |=> (usr_q == $past(usr_wdata)));

endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
    import swu_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [SW_W-1:0]   sw_wdata,
    output logic [SW_W-1:0]   sw_rdata,
    input  logic [FLAG_N-1:0] flag_we,
    input  logic [FLAG_N-1:0] flag_wdata,
    output logic              priv_o,
    output logic [MASK_W-1:0] imask_o,
    input  logic              sp_act_we,
    input  logic [PTR_W-1:0]  sp_act_wdata,
    output logic [PTR_W-1:0]  sp_act_q,
    input  logic              sp_usr_we,
    input  logic [PTR_W-1:0]  sp_usr_wdata,
    output logic [PTR_W-1:0]  sp_usr_q,
    input  logic              sp_sup_we,
    input  logic [PTR_W-1:0]  sp_sup_wdata,
    output logic [PTR_W-1:0]  sp_sup_q
);

    logic              priv_q;
    logic              enter_super;
    logic              leave_super;
    logic [MASK_W-1:0] mask_q;
    logic [FLAG_N-1:0] flags_q;
    logic [SW_W-1:0]   kept_w;

    assign kept_w = sw_wdata & SW_KEEP;

    swu_priv_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (sw_we),
        .wr_priv     (kept_w[PRIV_BIT]),
        .priv_q      (priv_q),
        .enter_super (enter_super),
        .leave_super (leave_super)
    );

    swu_ccr_bank u_ccr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we      (sw_we),
        .sw_mask    (kept_w[MASK_LO +: MASK_W]),
        .sw_flags   (kept_w[FLAG_N-1:0]),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .mask_q     (mask_q),
        .flags_q    (flags_q)
    );

    swu_stack_bank #(.PTR_W(PTR_W)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_super (enter_super),
        .leave_super (leave_super),
        .act_we      (sp_act_we),
        .act_wdata   (sp_act_wdata),
        .usr_we      (sp_usr_we),
        .usr_wdata   (sp_usr_wdata),
        .sup_we      (sp_sup_we),
        .sup_wdata   (sp_sup_wdata),
        .act_q       (sp_act_q),
        .usr_q       (sp_usr_q),
        .sup_q       (sp_sup_q)
    );

    assign sw_rdata = pack_word(priv_q, mask_q, flags_q);
    assign priv_o   = priv_q;
    assign imask_o  = mask_q;

    p_word_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (sw_rdata == $past(kept_w)));

    p_spare_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rdata & ~SW_KEEP) == '0);

endmodule

// File: tb/sim_status_word_unit.sv
module sim_status_word_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] sw_rdata;
    logic [4:0]  flag_we = '0;
    logic [4:0]  flag_wdata = '0;
    logic        priv_o;
    logic [2:0]  imask_o;
    logic        sp_act_we = 1'b0, sp_usr_we = 1'b0, sp_sup_we = 1'b0;
    logic [31:0] sp_act_wdata = '0, sp_usr_wdata = '0, sp_sup_wdata = '0;
    logic [31:0] sp_act_q, sp_usr_q, sp_sup_q;

    int total = 0;
    int bad = 0;
    logic [31:0] m_act = '0, m_usr = '0, m_sup = '0;

    always #2 clk = ~clk;

    status_word_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .priv_o(priv_o), .imask_o(imask_o),
        .sp_act_we(sp_act_we), .sp_act_wdata(sp_act_wdata), .sp_act_q(sp_act_q),
        .sp_usr_we(sp_usr_we), .sp_usr_wdata(sp_usr_wdata), .sp_usr_q(sp_usr_q),
        .sp_sup_we(sp_sup_we), .sp_sup_wdata(sp_sup_wdata), .sp_sup_q(sp_sup_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic s, input logic [2:0] m, input logic [4:0] f);
        return {2'b00, s, 2'b00, m, 3'b000, f};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
        sw_we = 1'b0; flag_we = '0;
        sp_act_we = 1'b0; sp_usr_we = 1'b0; sp_sup_we = 1'b0;
    endtask

    task automatic chk_ptrs(input string tag);
        chk({tag, " act"}, sp_act_q, m_act);
        chk({tag, " usr"}, sp_usr_q, m_usr);
        chk({tag, " sup"}, sp_sup_q, m_sup);
    endtask

    // bench model of a status write and its stack effect
    task automatic sw_write(input logic [15:0] w);
        logic [31:0] t;
        if (w[13] && !priv_o) begin
            t = m_act; m_act = m_sup; m_usr = t;
        end else if (!w[13] && priv_o) begin
            t = m_act; m_act = m_usr; m_sup = t;
        end
        sw_we = 1'b1; sw_wdata = w;
        step();
    endtask

    task automatic t_reset();
        chk("R8 word", {16'h0, sw_rdata}, 32'h2700);
        chk("R9 priv", {31'h0, priv_o}, 32'h1);
        chk("R9 mask", {29'h0, imask_o}, 32'h7);
        chk_ptrs("R8");
    endtask

    task automatic t_direct();
        sp_act_we = 1'b1; sp_act_wdata = 32'h0000_A000;
        sp_usr_we = 1'b1; sp_usr_wdata = 32'h0000_B000;
        sp_sup_we = 1'b1; sp_sup_wdata = 32'h0000_C000;
        m_act = 32'h0000_A000; m_usr = 32'h0000_B000; m_sup = 32'h0000_C000;
        step();
        chk_ptrs("R7 direct");
    endtask

    task automatic t_leave();
        sw_write(16'h0015);
        chk("R2 word", {16'h0, sw_rdata}, {16'h0, mk(1'b0, 3'd0, 5'b10101)});
        chk("R9 priv", {31'h0, priv_o}, 32'h0);
        chk_ptrs("R3 leave");
    endtask

    task automatic t_same_user();
        sp_act_we = 1'b1; sp_act_wdata = 32'h0000_1234; m_act = 32'h0000_1234;
        step();
        sw_write(16'h0703);
        chk("R2 word", {16'h0, sw_rdata}, {16'h0, mk(1'b0, 3'd7, 5'b00011)});
        chk_ptrs("R5 user");
    endtask

    task automatic t_enter();
        sw_write(16'hFFFF);
        chk("R1 spare bits", {16'h0, sw_rdata}, 32'h271F);
        chk("R9 mask", {29'h0, imask_o}, 32'h7);
        chk_ptrs("R4 enter");
    endtask

    task automatic t_same_super();
        sw_write(16'h2000);
        chk("R5 word", {16'h0, sw_rdata}, 32'h2000);
        chk_ptrs("R5 super");
    endtask

    task automatic t_flags();
        flag_we = 5'b01010; flag_wdata = 5'b11111;
        step();
        chk("R6 partial", {16'h0, sw_rdata}, 32'h200A);
        flag_we = 5'b10001; flag_wdata = 5'b00001;
        step();
        chk("R6 mixed", {16'h0, sw_rdata}, 32'h200B);
        sw_we = 1'b1; sw_wdata = 16'h2504; flag_we = 5'b11111; flag_wdata = 5'b11011;
        step();
        chk("R6 priority", {16'h0, sw_rdata}, 32'h2504);
    endtask

    task automatic t_swap_override();
        sp_act_we = 1'b1; sp_act_wdata = 32'h0000_A000;
        sp_usr_we = 1'b1; sp_usr_wdata = 32'h0000_B000;
        sp_sup_we = 1'b1; sp_sup_wdata = 32'h0000_C000;
        m_act = 32'h0000_A000; m_usr = 32'h0000_B000; m_sup = 32'h0000_C000;
        step();
        sp_act_we = 1'b1; sp_usr_we = 1'b1; sp_sup_we = 1'b1;
        sp_act_wdata = 32'hDEAD_0001; sp_usr_wdata = 32'hDEAD_0002; sp_sup_wdata = 32'hDEAD_0003;
        sw_write(16'h0000);
        chk_ptrs("R7 override leave");
        sp_act_we = 1'b1; sp_usr_we = 1'b1; sp_sup_we = 1'b1;
        sw_write(16'h2100);
        chk_ptrs("R7 override enter");
        chk("R9 mask", {29'h0, imask_o}, 32'h1);
    endtask

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_direct();
        t_leave();
        t_same_user();
        t_enter();
        t_same_super();
        t_flags();
        t_swap_override();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #20000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule